// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps one status record for each frame held in a receive buffer. The frame store itself lives elsewhere. The MAC side opens a record when a frame begins and counts its bytes. It closes the record when the frame ends and stores an error class with it. The host side sees one status word for the oldest frame, called the head frame. The host reads that frame byte by byte and then drops it with a discard strobe, which brings the next record forward.

The queue holds a fixed number of frames, eight by default. When it is full, new frames are refused and a status-overrun flag is raised. The block also counts the host's reads against the head frame's byte count. A read past the bytes received so far is fatal: a sticky underrun flag is set and an adapter-failure output is raised. Only a receive reset or a global reset clears it.

Top module: `rx_status_queue`

## Requirements
- R1: After `rst`, `head_status` is 16'h8000 and `rx_receiving`, `rx_complete`, `status_overrun`, `rx_underrun` and `adapter_fail` are all 0.
- R2: When the head frame is complete, `head_status` bit 15 is 0, bits 14..11 hold the stored error class, and bits 10..0 hold the number of cycles in which `wr_byte` was high while that frame was being received, including the cycle of `wr_end`.
- R3: The error class stored at `wr_end` is `wr_code` when that code is 1000 (overrun), 1011 (runt), 1100 (alignment), 1101 (CRC), 1001 (oversize) or 0010 (dribble). Any other code is stored as 0000. Status bit 14 is therefore 1 for exactly the first five classes.
- R4: When the queue is empty, `head_status` is 16'h8000. When the head frame is still arriving, bit 15 is 1, bits 14..11 are 0, and bits 10..0 show the bytes counted so far.
- R5: `rx_receiving` goes high in the cycle after an accepted `wr_start` and goes low in the cycle after `wr_end`. A `wr_start` while a frame is being received is ignored.
- R6: `status_overrun` is 1 exactly while DEPTH frames are held. A `wr_start` in that state opens no record, and `rx_receiving` stays 0. The flag clears in the cycle after a discard.
- R7: `discard` removes a completed head frame and resets the host read count. It is ignored when the queue is empty or when the head frame is still arriving.
- R8: `rx_complete` is 1 exactly when the queue is non-empty and its head frame is complete, that is, when `head_status` bit 15 is 0.
- R9: An `rd_byte` when the queue is empty, or when the head frame's reads already equal its byte count, sets `rx_underrun` and `adapter_fail`. Both stay set until `rx_reset` or `rst`.
- R10: A one-cycle `rx_reset` empties the queue, ends any frame in progress, and clears both flags, with the same visible state as after R1.
- R11: A frame's byte count saturates at MAX_BYTES (1514 by default).
- R12: Frames are presented at the head in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| rx_reset | input | 1 | Receive reset strobe, clears queue and flags |
| wr_start | input | 1 | MAC side: a new frame begins |
| wr_byte | input | 1 | MAC side: one byte of the current frame stored |
| wr_end | input | 1 | MAC side: current frame finished |
| wr_code | input | 4 | MAC side: raw error code, sampled with wr_end |
| rd_byte | input | 1 | Host side: one byte of the head frame read |
| discard | input | 1 | Host side: drop the head frame |
| head_status | output | 16 | Head frame status word |
| rx_complete | output | 1 | Head frame fully received |
| rx_receiving | output | 1 | A frame is being written |
| status_overrun | output | 1 | Queue holds DEPTH frames |
| rx_underrun | output | 1 | Sticky: host read past the received bytes |
| adapter_fail | output | 1 | Failure indication raised by the underrun |

## Verification
All sixteen raw error codes are swept, each with a different byte count. This separates codes that must be kept from codes that must be folded to 0000, and it shows that bit 14 follows the class rather than the raw code. Frame trains of DEPTH+1 frames with distinct lengths test arrival order and show that the refused frame leaves no record. Read counts from zero to several bytes, with a discard between two frames of equal length, place the underrun edge exactly and show that discard rewinds the read count. Long frames check saturation, and resets issued mid-frame check that R10 clears every piece of state.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CLASS_W = 4;

  // Keep only the recognised error classes; everything else reads as clean.
  function automatic logic [CLASS_W-1:0] rxq_class(input logic [CLASS_W-1:0] raw);
    case (raw)
      4'b1000, 4'b1011, 4'b1100,
      4'b1101, 4'b1001, 4'b0010: return raw;
      default:                   return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_start,
  input  logic             wr_end,
  input  logic             discard,
  input  logic             head_done,
  output logic             push,
  output logic             pop,
  output logic             fin,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W-1:0] act_idx,
  output logic [OCC_W-1:0] occ,
  output logic             receiving,
  output logic             full
);
  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (occ == OCC_W'(DEPTH));
  assign push = wr_start && !receiving && !full;
  assign pop  = discard && (occ != '0) && head_done;
  assign fin  = wr_end && receiving;

  always_ff @(posedge clk) begin
    if (clr) begin
      head_idx  <= '0;
      tail_idx  <= '0;
      act_idx   <= '0;
      occ       <= '0;
      receiving <= 1'b0;
    end else begin
      if (push) begin
        tail_idx  <= bump(tail_idx);
        act_idx   <= tail_idx;
        receiving <= 1'b1;
      end else if (fin) begin
        receiving <= 1'b0;
      end
      if (pop) head_idx <= bump(head_idx);
      occ <= occ + OCC_W'(push) - OCC_W'(pop);
    end
  end

  assert_occ_cap_R6: assert property (@(posedge clk) disable iff (clr)
    occ <= OCC_W'(DEPTH));
  assert_refuse_full_R6: assert property (@(posedge clk) disable iff (clr)
    full |=> (occ <= $past(occ)));
  assert_one_open_R5: assert property (@(posedge clk) disable iff (clr)
    (receiving && !fin) |=> (receiving && $stable(act_idx)));
endmodule

// File: rtl/rxq_records.sv
module rxq_records
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 11,
  parameter int MAX_BYTES = 1514,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               push,
  input  logic               fin,
  input  logic               byte_en,
  input  logic [IDX_W-1:0]   tail_idx,
  input  logic [IDX_W-1:0]   act_idx,
  input  logic [IDX_W-1:0]   head_idx,
  input  logic [CLASS_W-1:0] wr_code,
  output logic [CNT_W-1:0]   head_bytes,
  output logic [CLASS_W-1:0] head_class,
  output logic               head_done
);
  logic [CNT_W-1:0]   bytes_q [DEPTH];
  logic [CLASS_W-1:0] class_q [DEPTH];
  logic               done_q  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rec
    always_ff @(posedge clk) begin
      if (clr) begin
        bytes_q[i] <= '0;
        class_q[i] <= '0;
        done_q[i]  <= 1'b0;
      end else if (push && tail_idx == IDX_W'(i)) begin
        bytes_q[i] <= '0;
        class_q[i] <= '0;
        done_q[i]  <= 1'b0;
      end else if (act_idx == IDX_W'(i)) begin
        if (byte_en && bytes_q[i] < CNT_W'(MAX_BYTES))
          bytes_q[i] <= bytes_q[i] + 1'b1;
        if (fin) begin
          done_q[i]  <= 1'b1;
          class_q[i] <= rxq_class(wr_code);
        end
      end
    end

    assert_count_sat_R11: assert property (@(posedge clk) disable iff (clr)
      bytes_q[i] <= CNT_W'(MAX_BYTES));
  end

  assign head_bytes = bytes_q[head_idx];
  assign head_class = class_q[head_idx];
  assign head_done  = done_q[head_idx];
endmodule

// File: rtl/rxq_rdtrack.sv
module rxq_rdtrack #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             rd_byte,
  input  logic             head_valid,
  input  logic [CNT_W-1:0] head_bytes,
  input  logic             pop,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             underrun
);
  logic overread;
  assign overread = rd_byte && (!head_valid || rd_cnt >= head_bytes);

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_cnt   <= '0;
      underrun <= 1'b0;
    end else begin
      if (overread) underrun <= 1'b1;
      if (pop)
        rd_cnt <= '0;
      else if (rd_byte && !overread)
        rd_cnt <= rd_cnt + 1'b1;
    end
  end

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (clr)
    underrun |=> underrun);
  assert_pop_rewind_R7: assert property (@(posedge clk) disable iff (clr)
    pop |=> (rd_cnt == '0));
  assert_reads_bounded_R9: assert property (@(posedge clk) disable iff (clr)
    head_valid |-> (rd_cnt <= head_bytes));
endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 11,
  parameter int MAX_BYTES = 1514,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int STAT_W = 1 + CLASS_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_reset,
  input  logic              wr_start,
  input  logic              wr_byte,
  input  logic              wr_end,
  input  logic [CLASS_W-1:0] wr_code,
  input  logic              rd_byte,
  input  logic              discard,
  output logic [STAT_W-1:0] head_status,
  output logic              rx_complete,
  output logic              rx_receiving,
  output logic              status_overrun,
  output logic              rx_underrun,
  output logic              adapter_fail
);
  logic               clr;
  logic               push, pop, fin, full, head_done, head_valid;
  logic [IDX_W-1:0]   head_idx, tail_idx, act_idx;
  logic [OCC_W-1:0]   occ;
  logic [CNT_W-1:0]   head_bytes, rd_cnt;
  logic [CLASS_W-1:0] head_class;

  assign clr = rst | rx_reset;

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .clr(clr), .wr_start(wr_start), .wr_end(wr_end),
    .discard(discard), .head_done(head_done), .push(push), .pop(pop),
    .fin(fin), .head_idx(head_idx), .tail_idx(tail_idx), .act_idx(act_idx),
    .occ(occ), .receiving(rx_receiving), .full(full)
  );

  rxq_records #(.DEPTH(DEPTH), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_recs (
    .clk(clk), .clr(clr), .push(push), .fin(fin),
    .byte_en(wr_byte && rx_receiving), .tail_idx(tail_idx),
    .act_idx(act_idx), .head_idx(head_idx), .wr_code(wr_code),
    .head_bytes(head_bytes), .head_class(head_class), .head_done(head_done)
  );

  assign head_valid = (occ != '0);

  rxq_rdtrack #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .clr(clr), .rd_byte(rd_byte), .head_valid(head_valid),
    .head_bytes(head_bytes), .pop(pop), .rd_cnt(rd_cnt), .underrun(rx_underrun)
  );

  always_comb begin
    if (!head_valid)
      head_status = {1'b1, {CLASS_W{1'b0}}, {CNT_W{1'b0}}};
    else if (head_done)
      head_status = {1'b0, head_class, head_bytes};
    else
      head_status = {1'b1, {CLASS_W{1'b0}}, head_bytes};
  end

  assign rx_complete    = head_valid && head_done;
  assign status_overrun = full;
  assign adapter_fail   = rx_underrun;

  assert_empty_busy_R4: assert property (@(posedge clk) disable iff (clr)
    !head_valid |-> head_status[STAT_W-1]);
  assert_complete_flag_R8: assert property (@(posedge clk) disable iff (clr)
    rx_complete |-> !head_status[STAT_W-1]);
  assert_fail_tracks_R9: assert property (@(posedge clk) disable iff (clr)
    $rose(rx_underrun) |-> adapter_fail);
  assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (clr)
    (status_overrun && pop) |=> !status_overrun);
endmodule

// File: tb/rx_status_queue_test.sv
module rx_status_queue_test;
  logic clk = 1'b0;
  logic rst = 1'b1, rx_reset = 1'b0;
  logic wr_start = 1'b0, wr_byte = 1'b0, wr_end = 1'b0;
  logic [3:0] wr_code = '0;
  logic rd_byte = 1'b0, discard = 1'b0;
  logic [15:0] head_status;
  logic rx_complete, rx_receiving, status_overrun, rx_underrun, adapter_fail;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  rx_status_queue uut (
    .clk(clk), .rst(rst), .rx_reset(rx_reset), .wr_start(wr_start),
    .wr_byte(wr_byte), .wr_end(wr_end), .wr_code(wr_code), .rd_byte(rd_byte),
    .discard(discard), .head_status(head_status), .rx_complete(rx_complete),
    .rx_receiving(rx_receiving), .status_overrun(status_overrun),
    .rx_underrun(rx_underrun), .adapter_fail(adapter_fail)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<150000", cycles);
      summary();
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_class(logic [3:0] c);
    if (c == 4'h8 || c == 4'hB || c == 4'hC || c == 4'hD || c == 4'h9 || c == 4'h2)
      return c;
    return 4'h0;
  endfunction

  function automatic logic [15:0] done_word(int n, logic [3:0] c);
    int s = (n > 1514) ? 1514 : n;
    return {1'b0, exp_class(c), 11'(s)};
  endfunction

  task automatic open_frame();
    wr_start = 1'b1; tick(); wr_start = 1'b0;
  endtask
  task automatic add_bytes(int n);
    for (int i = 0; i < n; i++) begin wr_byte = 1'b1; tick(); end
    wr_byte = 1'b0;
  endtask
  task automatic close_frame(logic [3:0] c);
    wr_code = c; wr_end = 1'b1; tick(); wr_end = 1'b0; wr_code = '0;
  endtask
  task automatic send(int n, logic [3:0] c);
    open_frame(); add_bytes(n); close_frame(c);
  endtask
  task automatic drop(); discard = 1'b1; tick(); discard = 1'b0; endtask
  task automatic reads(int n);
    for (int i = 0; i < n; i++) begin rd_byte = 1'b1; tick(); end
    rd_byte = 1'b0;
  endtask
  task automatic rxr(); rx_reset = 1'b1; tick(); rx_reset = 1'b0; endtask

  task automatic idle_state(string req);
    chk(req, head_status, 16'h8000);
    chk(req, {11'b0, rx_complete, rx_receiving, status_overrun, rx_underrun, adapter_fail}, 16'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    idle_state("R1 reset");

    // In progress then complete
    open_frame();
    chk("R5 receiving after start", 16'(rx_receiving), 16'h1);
    add_bytes(3);
    chk("R4 in-progress word", head_status, 16'h8003);
    chk("R8 not complete", 16'(rx_complete), 16'h0);
    wr_start = 1'b1; tick(); wr_start = 1'b0;   // ignored second start
    close_frame(4'hD);
    chk("R2 done word", head_status, 16'h6803);
    chk("R5 receiving low after end", 16'(rx_receiving), 16'h0);
    chk("R8 complete", 16'(rx_complete), 16'h1);
    drop();
    chk("R5 stray start made no record", head_status, 16'h8000);

    // Sweep of raw codes
    for (int c = 0; c < 16; c++) begin
      send(c * 37 + 1, 4'(c));
      chk("R3 class sweep", head_status, done_word(c * 37 + 1, 4'(c)));
      chk("R3 bit14 error", 16'(head_status[14]),
          16'(exp_class(4'(c)) inside {4'h8, 4'h9, 4'hB, 4'hC, 4'hD}));
      drop();
    end

    // Byte and end in the same cycle
    open_frame(); add_bytes(2);
    wr_byte = 1'b1; close_frame(4'h2); wr_byte = 1'b0;
    chk("R2 byte with end", head_status, done_word(3, 4'h2));
    drop();

    // Cap and order
    for (int k = 0; k < 8; k++) send(10 + k, 4'h0);
    chk("R6 overrun at cap", 16'(status_overrun), 16'h1);
    open_frame();
    chk("R6 refused start", 16'(rx_receiving), 16'h0);
    add_bytes(4); close_frame(4'h8);
    for (int k = 0; k < 8; k++) begin
      chk("R12 order", head_status, done_word(10 + k, 4'h0));
      drop();
      chk("R6 overrun cleared", 16'(status_overrun), 16'h0);
    end
    chk("R6 refused frame absent", head_status, 16'h8000);

    // Discard ignored cases
    drop();
    chk("R7 empty discard", head_status, 16'h8000);
    open_frame(); add_bytes(2); drop();
    chk("R7 in-progress discard", head_status, 16'h8002);
    close_frame(4'hC);
    chk("R7 frame kept", head_status, done_word(2, 4'hC));
    drop();

    // Underrun edge sweep with read rewind
    for (int n = 0; n < 5; n++) begin
      send(n, 4'h0); send(n, 4'h0);
      reads(n);
      chk("R9 exact reads ok", 16'(rx_underrun), 16'h0);
      drop(); reads(n);
      chk("R7 rewind on discard", 16'(rx_underrun), 16'h0);
      reads(1);
      chk("R9 overread flag", 16'(rx_underrun), 16'h1);
      chk("R9 adapter fail", 16'(adapter_fail), 16'h1);
      repeat (3) tick();
      chk("R9 sticky", 16'(rx_underrun), 16'h1);
      rxr();
      idle_state("R10 rx_reset clears");
    end
    reads(1);
    chk("R9 empty read", 16'(rx_underrun), 16'h1);

    // Reset mid-frame with queued frames
    rxr();
    send(5, 4'h8); open_frame(); add_bytes(3);
    rxr();
    idle_state("R10 mid-frame reset");

    // Saturation
    send(1520, 4'h9);
    chk("R11 saturate", head_status, done_word(1520, 4'h9));
    drop();
    send(1514, 4'h0);
    chk("R11 at limit", head_status, 16'(1514));
    drop();

    summary();
  end
endmodule